// File: doc/BRIEF.md
# Count-Driven Master Transfer Sequencer

This block runs the master side of a byte-level bus transaction. Software programs a slave address and a byte count, loads outgoing bytes into a small data queue, and sets control bits. The block then issues one bus operation at a time: open with address and direction, send a byte and get its acknowledge, receive a byte, or close. It keeps going until the working count is used up or the far end refuses a byte. At that point it either closes the transaction by itself or reports access-ready and leaves master mode. A repeat mode ignores the count. It keeps the queue drained (transmit) or filled (receive) and closes only when software asks.

The control word uses these bits: enable (bit 15), master (bit 10), transmit (bit 9), repeat (bit 2), stop request (bit 1) and start request (bit 0). Bits 14, 11, 10, 9, 8, 2, 1 and 0 are stored as written, with enable also kept. Status flags are NACK (bit 0), access-ready (bit 1), receive-ready (bit 2) and transmit-ready (bit 3). They are sticky and are cleared by writing ones to `stat_clr`.

The bus interface is a request/done handshake. `bus_req` pulses for one cycle with `bus_op` set to open (0), send (1), receive (2) or close (3). The bus answers later with a one-cycle `bus_done` that carries `bus_ack` and, for a receive, `bus_rbyte`.

The sequencer has six states:
- IDLE waits. It goes to ADDR when start and master are both set. It goes to EVAL when the bus is held and a host data access has been seen since the last evaluation.
- ADDR waits for the address answer. It goes to EVAL on an acknowledge and back to IDLE on a refusal.
- EVAL decides the next step in one cycle. It goes to SEND, RECV or STOP, or back to IDLE.
- SEND returns to EVAL on an acknowledge and to IDLE on a refusal.
- RECV returns to EVAL.
- STOP returns to IDLE and frees the bus.

A control write with enable clear forces IDLE from any state.

Top module: `mxs_xfer_seq`

## Requirements
- R1: A control write stores the written value ANDed with 0xCF07, and reading it back returns that value while enable (bit 15) is set.
- R2: At reset, and after a control write with bit 15 clear, the control word, programmed count, working count, slave address, data queue, status and busy flag all read zero.
- R3: With enable, master (bit 10) and start (bit 0) set, the block issues one open operation (`bus_op`=0) with the stored slave address and `bus_rd` equal to the inverse of transmit (bit 9); start then reads back as 0.
- R4: A refused open sets NACK (status bit 0), clears stop (bit 1), leaves `busy` low and sends no byte; writing 1 to `stat_clr` bit 0 clears the flag.
- R5: In normal transmit, queued bytes are sent in the order they were written while the working count is nonzero; each send decrements the working count, and reading the count port returns the working count.
- R6: When the working count reaches zero with stop set, a close operation (`bus_op`=3) is issued, stop clears, `busy` drops and the working count reloads from the programmed count.
- R7: When the working count reaches zero with stop clear, no close is issued, access-ready (status bit 1) is set and master clears.
- R8: In normal receive, bytes are received until the count is zero or the queue holds FIFO_DEPTH (4) bytes, receive-ready (status bit 2) is set, and host reads return them oldest first.
- R9: A host read that empties the queue while master is set and transmit is clear sets access-ready and clears master.
- R10: In normal transmit, when the queue empties with a nonzero working count, transmit-ready (status bit 3) is set and the transaction stays open.
- R11: In repeat mode (bit 2) without stop, transmit sends every queued byte and sets transmit-ready, receive fills the queue to 4 bytes and sets receive-ready, and the working count is unchanged.
- R12: In repeat mode, a pending stop closes the transaction at the next evaluation without moving bytes and reloads the working count.
- R13: A refused byte send ends sending, sets NACK and clears stop; bytes still queued remain readable.
- R14: Evaluation runs only after a host data access while the bus is held, and host data accesses with the bus free cause no bus operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_rdata | output | 16 | Control word readback |
| cnt_we | input | 1 | Byte count write strobe (also loads working count) |
| cnt_wdata | input | CNT_W | Byte count write value |
| cnt_rdata | output | CNT_W | Working count |
| sa_we | input | 1 | Slave address write strobe |
| sa_wdata | input | ADDR_W | Slave address value |
| dat_we | input | 1 | Push one byte into the data queue |
| dat_wdata | input | 8 | Byte to push |
| dat_re | input | 1 | Pop the oldest byte from the data queue |
| dat_rdata | output | 8 | Oldest queued byte (zero when empty) |
| stat_clr | input | 4 | Write-one-to-clear for status flags |
| stat | output | 4 | Status flags: NACK, access-ready, receive-ready, transmit-ready |
| busy | output | 1 | Bus held by an open transaction |
| bus_req | output | 1 | One-cycle bus operation request |
| bus_op | output | 2 | Operation: 0 open, 1 send, 2 receive, 3 close |
| bus_addr | output | ADDR_W | Slave address for open |
| bus_rd | output | 1 | Read direction for open |
| bus_wbyte | output | 8 | Byte for send |
| bus_done | input | 1 | Operation completed |
| bus_ack | input | 1 | Acknowledge for open or send |
| bus_rbyte | input | 8 | Byte returned by receive |

## Verification
A wrong working count shows up at the count port right after the affected send or receive completes. One bus operation later it also shows up as a close issued one byte early or late, or as access-ready set when it should not be. A lost stop request, or a queue pointer that wandered, shows up within a single evaluation: the bench sees an extra or missing close, or bytes sent or returned out of order. A NACK that fails to cancel the stop is visible on the next control readback and by the absence of a close operation on the bus.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

    typedef enum logic [1:0] {
        OP_OPEN  = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_CLOSE = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_EVAL,
        S_SEND,
        S_RECV,
        S_STOP
    } seq_state_e;

    localparam int CTL_EN  = 15;
    localparam int CTL_MST = 10;
    localparam int CTL_TRX = 9;
    localparam int CTL_REP = 2;
    localparam int CTL_STP = 1;
    localparam int CTL_STT = 0;
    localparam logic [15:0] CTL_KEEP = 16'hCF07;

    localparam int ST_NACK = 0;
    localparam int ST_ARDY = 1;
    localparam int ST_RRDY = 2;
    localparam int ST_XRDY = 3;

endpackage

// File: rtl/mxs_fifo.sv
module mxs_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = empty ? '0 : mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      level <= level + LW'(1);
            else if (do_pop && !do_push) level <= level - LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    // R8: the queue never holds more than its depth
    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == LW'(DEPTH)));

endmodule

// File: rtl/mxs_wcnt.sv
module mxs_wcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         prog_we,
    input  logic [W-1:0] prog_wdata,
    input  logic         reload,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         zero
);

    logic [W-1:0] prog_q;

    assign zero = (value == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= '0;
            value  <= '0;
        end else if (clr) begin
            prog_q <= '0;
            value  <= '0;
        end else if (prog_we) begin
            prog_q <= prog_wdata;
            value  <= prog_wdata;
        end else if (reload) begin
            value <= prog_q;
        end else if (dec && !zero) begin
            value <= value - W'(1);
        end
    end

    // R2: a clear empties both the programmed and the working count
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));

endmodule

// File: rtl/mxs_xfer_seq.sv
module mxs_xfer_seq
    import mxs_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int ADDR_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [15:0]       ctl_wdata,
    output logic [15:0]       ctl_rdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_rdata,
    input  logic              sa_we,
    input  logic [ADDR_W-1:0] sa_wdata,
    input  logic              dat_we,
    input  logic [7:0]        dat_wdata,
    input  logic              dat_re,
    output logic [7:0]        dat_rdata,
    input  logic [3:0]        stat_clr,
    output logic [3:0]        stat,
    output logic              busy,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic [7:0]        bus_wbyte,
    input  logic              bus_done,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rbyte
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    seq_state_e        state_q, state_d;
    logic [15:0]       ctl_q;
    logic [ADDR_W-1:0] sa_q;
    logic [3:0]        stat_q, stat_set;
    logic              busy_q, kick_q;
    bus_op_e           op_q;

    logic c_mst, c_trx, c_rep, c_stp, c_stt;
    logic soft_rst;

    logic             f_push, f_pop, f_empty, f_full;
    logic [7:0]       f_wdata, f_rdata;
    logic [LVL_W-1:0] f_level;

    logic             c_dec, c_reload, cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    logic go_start, go_eval;
    logic addr_ok, addr_nak, send_done, send_nak, recv_done, stop_done;
    logic ev_send, ev_recv, ev_stop, ev_ardy, ev_xrdy, ev_rrdy;
    logic host_pop, rx_drain;

    assign c_mst = ctl_q[CTL_MST];
    assign c_trx = ctl_q[CTL_TRX];
    assign c_rep = ctl_q[CTL_REP];
    assign c_stp = ctl_q[CTL_STP];
    assign c_stt = ctl_q[CTL_STT];

    assign soft_rst = ctl_we && !ctl_wdata[CTL_EN];

    // ---------------- event decode ----------------
    assign go_start  = (state_q == S_IDLE) && c_stt && c_mst;
    assign go_eval   = (state_q == S_IDLE) && !(c_stt && c_mst) && busy_q && kick_q;
    assign addr_ok   = (state_q == S_ADDR) && bus_done && bus_ack;
    assign addr_nak  = (state_q == S_ADDR) && bus_done && !bus_ack;
    assign send_done = (state_q == S_SEND) && bus_done;
    assign send_nak  = send_done && !bus_ack;
    assign recv_done = (state_q == S_RECV) && bus_done;
    assign stop_done = (state_q == S_STOP) && bus_done;

    // ---------------- evaluation decision ----------------
    always_comb begin
        ev_send = 1'b0;
        ev_recv = 1'b0;
        ev_stop = 1'b0;
        ev_ardy = 1'b0;
        ev_xrdy = 1'b0;
        ev_rrdy = 1'b0;
        if (state_q == S_EVAL) begin
            if (c_rep) begin
                if (c_stp)        ev_stop = 1'b1;
                else if (c_trx) begin
                    if (!f_empty) ev_send = 1'b1;
                    else          ev_xrdy = 1'b1;
                end else begin
                    if (!f_full)  ev_recv = 1'b1;
                    else          ev_rrdy = 1'b1;
                end
            end else begin
                if (c_trx && !cnt_zero && !f_empty) begin
                    ev_send = 1'b1;
                end else if (!c_trx && !cnt_zero && !f_full) begin
                    ev_recv = 1'b1;
                end else begin
                    ev_xrdy = c_trx && !cnt_zero;
                    ev_rrdy = !c_trx && !f_empty;
                    if (cnt_zero) begin
                        if (c_stp) ev_stop = 1'b1;
                        else       ev_ardy = 1'b1;
                    end
                end
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (go_start)     state_d = S_ADDR;
                else if (go_eval) state_d = S_EVAL;
            end
            S_ADDR: begin
                if (bus_done) state_d = bus_ack ? S_EVAL : S_IDLE;
            end
            S_EVAL: begin
                if (ev_send)      state_d = S_SEND;
                else if (ev_recv) state_d = S_RECV;
                else if (ev_stop) state_d = S_STOP;
                else              state_d = S_IDLE;
            end
            S_SEND: begin
                if (bus_done) state_d = bus_ack ? S_EVAL : S_IDLE;
            end
            S_RECV: begin
                if (bus_done) state_d = S_EVAL;
            end
            S_STOP: begin
                if (bus_done) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= S_IDLE;
        else if (soft_rst) state_q <= S_IDLE;
        else               state_q <= state_d;
    end

    // ---------------- bus request outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            op_q      <= OP_OPEN;
            bus_addr  <= '0;
            bus_rd    <= 1'b0;
            bus_wbyte <= '0;
        end else if (soft_rst) begin
            bus_req <= 1'b0;
        end else begin
            bus_req <= go_start || ev_send || ev_recv || ev_stop;
            if (go_start) begin
                op_q     <= OP_OPEN;
                bus_addr <= sa_q;
                bus_rd   <= !c_trx;
            end else if (ev_send) begin
                op_q      <= OP_SEND;
                bus_wbyte <= f_rdata;
            end else if (ev_recv) begin
                op_q <= OP_RECV;
            end else if (ev_stop) begin
                op_q <= OP_CLOSE;
            end
        end
    end
    assign bus_op = op_q;

    // ---------------- control, status, busy, kick ----------------
    assign host_pop = dat_re && !f_empty && !ev_send;
    assign rx_drain = host_pop && (f_level == LVL_W'(1)) && c_mst && !c_trx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata[CTL_EN] ? (ctl_wdata & CTL_KEEP) : '0;
        end else begin
            if ((state_q == S_IDLE) && c_stt)        ctl_q[CTL_STT] <= 1'b0;
            if (addr_nak || send_nak || stop_done)   ctl_q[CTL_STP] <= 1'b0;
            if (ev_ardy || rx_drain)                 ctl_q[CTL_MST] <= 1'b0;
        end
    end

    always_comb begin
        stat_set          = '0;
        stat_set[ST_NACK] = addr_nak || send_nak;
        stat_set[ST_ARDY] = ev_ardy || rx_drain;
        stat_set[ST_RRDY] = ev_rrdy;
        stat_set[ST_XRDY] = ev_xrdy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            busy_q <= 1'b0;
            kick_q <= 1'b0;
            sa_q   <= '0;
        end else if (soft_rst) begin
            stat_q <= '0;
            busy_q <= 1'b0;
            kick_q <= 1'b0;
            sa_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (addr_ok)        busy_q <= 1'b1;
            else if (stop_done) busy_q <= 1'b0;
            if (go_eval)                       kick_q <= 1'b0;
            if ((dat_we || dat_re) && busy_q)  kick_q <= 1'b1;
            if (sa_we) sa_q <= sa_wdata;
        end
    end

    assign ctl_rdata = ctl_q;
    assign stat      = stat_q;
    assign busy      = busy_q;
    assign cnt_rdata = cnt_val;
    assign dat_rdata = f_rdata;

    // ---------------- data queue ----------------
    assign f_push  = recv_done || dat_we;
    assign f_wdata = recv_done ? bus_rbyte : dat_wdata;
    assign f_pop   = ev_send || host_pop;

    mxs_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (8)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .rdata (f_rdata),
        .empty (f_empty),
        .full  (f_full),
        .level (f_level)
    );

    // ---------------- working counter ----------------
    assign c_dec    = (send_done || recv_done) && !c_rep;
    assign c_reload = stop_done;

    mxs_wcnt #(
        .W (CNT_W)
    ) u_wcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .prog_we    (cnt_we),
        .prog_wdata (cnt_wdata),
        .reload     (c_reload),
        .dec        (c_dec),
        .value      (cnt_val),
        .zero       (cnt_zero)
    );

    // ---------------- assertions ----------------
    // R3: the start request reads back clear once the open is on the bus
    a_r3_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_op == OP_OPEN) && !$past(ctl_we)) |-> !ctl_rdata[CTL_STT]);

    // R5: normal-mode sends only go out with a nonzero working count
    a_r5_send_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_op == OP_SEND) && !ctl_rdata[CTL_REP] && !$past(cnt_we))
        |-> (cnt_rdata != '0));

    // R6: a completed close frees the bus and drops the stop request
    a_r6_close_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_STOP) && bus_done && !ctl_we) |=> (!busy && !ctl_rdata[CTL_STP]));

    // R13: a refused byte flags NACK and cancels a pending stop
    a_r13_nack_drops_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_SEND) && bus_done && !bus_ack && !ctl_we)
        |=> (!ctl_rdata[CTL_STP] && stat[ST_NACK]));

    // R14: the bus is only held after an acknowledged open
    a_r14_busy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past((state_q == S_ADDR) && bus_done && bus_ack));

endmodule

// File: tb/mxs_xfer_seq_tb.sv
module mxs_xfer_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int SETTLE     = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [15:0] cnt_rdata;
    logic        sa_we = 1'b0;
    logic [9:0]  sa_wdata = '0;
    logic        dat_we = 1'b0;
    logic [7:0]  dat_wdata = '0;
    logic        dat_re = 1'b0;
    logic [7:0]  dat_rdata;
    logic [3:0]  stat_clr = '0;
    logic [3:0]  stat;
    logic        busy;
    logic        bus_req;
    logic [1:0]  bus_op;
    logic [9:0]  bus_addr;
    logic        bus_rd;
    logic [7:0]  bus_wbyte;
    logic        bus_done = 1'b0;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rbyte = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int         n_open = 0, n_send = 0, n_recv = 0, n_close = 0;
    logic [7:0] sent [32];
    logic [9:0] last_addr = '0;
    logic       last_rd = 1'b0;
    bit         open_ack = 1'b1;
    int         nack_at = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mxs_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .sa_we(sa_we), .sa_wdata(sa_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re), .dat_rdata(dat_rdata),
        .stat_clr(stat_clr), .stat(stat), .busy(busy),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wbyte(bus_wbyte), .bus_done(bus_done), .bus_ack(bus_ack), .bus_rbyte(bus_rbyte)
    );

    // Bus responder: answers each request LAT cycles later
    initial begin
        bit         pend;
        int         dly;
        logic [1:0] op;
        logic [7:0] wb;
        pend = 1'b0;
        dly  = 0;
        op   = '0;
        wb   = '0;
        forever begin
            @(posedge clk);
            bus_done <= 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    pend = 1'b0;
                    bus_done <= 1'b1;
                    bus_ack  <= 1'b1;
                    case (op)
                        2'd0: begin n_open++; bus_ack <= open_ack; end
                        2'd1: begin
                            if (n_send < 32) sent[n_send] = wb;
                            bus_ack <= (n_send != nack_at);
                            n_send++;
                        end
                        2'd2: begin bus_rbyte <= 8'(8'hA0 + n_recv); n_recv++; end
                        default: n_close++;
                    endcase
                end else begin
                    dly--;
                end
            end else if (bus_req) begin
                pend = 1'b1;
                dly  = LAT;
                op   = bus_op;
                wb   = bus_wbyte;
                if (bus_op == 2'd0) begin
                    last_addr = bus_addr;
                    last_rd   = bus_rd;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic wr_sa(input logic [9:0] v);
        @(negedge clk); sa_we = 1'b1; sa_wdata = v;
        @(negedge clk); sa_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); dat_we = 1'b1; dat_wdata = v;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic rd_dat(output logic [7:0] b);
        @(negedge clk); dat_re = 1'b1; b = dat_rdata;
        @(negedge clk); dat_re = 1'b0;
    endtask

    task automatic clr_stat(input logic [3:0] v);
        @(negedge clk); stat_clr = v;
        @(negedge clk); stat_clr = '0;
    endtask

    task automatic t_reset_state();
        chk("R2 reset ctl", ctl_rdata, 0);
        chk("R2 reset cnt", cnt_rdata, 0);
        chk("R2 reset stat", stat, 0);
        chk("R2 reset busy", busy, 0);
        chk("R2 reset bus_req", bus_req, 0);
    endtask

    task automatic t_mask_and_clear();
        wr_cnt(16'd5);
        wr_sa(10'h12);
        wr_ctl(16'hFFFE);
        chk("R1 masked readback", ctl_rdata, 16'hCF06);
        wr_ctl(16'h7FFF);
        chk("R2 enable clear ctl", ctl_rdata, 0);
        chk("R2 enable clear cnt", cnt_rdata, 0);
    endtask

    task automatic t_tx_auto_stop();
        int s0, c0;
        wr_ctl(16'h0000);
        wr_sa(10'h155);
        wr_cnt(16'd3);
        s0 = n_send; c0 = n_close;
        wr_dat(8'h11); wr_dat(8'h22); wr_dat(8'h33);
        settle();
        chk("R14 idle bus no send", n_send - s0, 0);
        wr_ctl(16'h8603);
        settle();
        chk("R3 open addr", last_addr, 10'h155);
        chk("R3 open dir write", last_rd, 0);
        chk("R5 sends", n_send - s0, 3);
        chk("R5 byte0", sent[s0], 8'h11);
        chk("R5 byte1", sent[s0+1], 8'h22);
        chk("R5 byte2", sent[s0+2], 8'h33);
        chk("R6 close issued", n_close - c0, 1);
        chk("R6 ctl after close", ctl_rdata, 16'h8600);
        chk("R6 count reload", cnt_rdata, 3);
        chk("R6 busy drop", busy, 0);
        chk("R3 R6 no nack no ardy", stat & 4'h3, 0);
    endtask

    task automatic t_tx_no_stop();
        int s0, c0;
        wr_ctl(16'h0000);
        wr_cnt(16'd2);
        s0 = n_send; c0 = n_close;
        wr_dat(8'h51); wr_dat(8'h52);
        wr_ctl(16'h8601);
        settle();
        chk("R7 sends", n_send - s0, 2);
        chk("R7 no close", n_close - c0, 0);
        chk("R7 ardy", stat[1], 1);
        chk("R7 master cleared", ctl_rdata, 16'h8200);
        chk("R5 count read zero", cnt_rdata, 0);
        chk("R7 still busy", busy, 1);
        wr_ctl(16'h0000);
        chk("R2 busy cleared", busy, 0);
    endtask

    task automatic t_tx_underrun();
        int s0, c0;
        wr_ctl(16'h0000);
        wr_cnt(16'd4);
        s0 = n_send; c0 = n_close;
        wr_dat(8'h41); wr_dat(8'h42);
        wr_ctl(16'h8601);
        settle();
        chk("R10 partial sends", n_send - s0, 2);
        chk("R10 xrdy", stat[3], 1);
        chk("R5 working count", cnt_rdata, 2);
        chk("R10 stays open", busy, 1);
        clr_stat(4'hF);
        wr_dat(8'h43);
        settle();
        chk("R14 write retriggers", n_send - s0, 3);
        chk("R5 byte after retrigger", sent[s0+2], 8'h43);
        chk("R10 xrdy again", stat[3], 1);
        wr_ctl(16'h8602);
        wr_dat(8'h44);
        settle();
        chk("R6 final send", sent[s0+3], 8'h44);
        chk("R6 close on zero", n_close - c0, 1);
        chk("R6 reload to programmed", cnt_rdata, 4);
    endtask

    task automatic t_open_nack();
        int s0;
        wr_ctl(16'h0000);
        wr_cnt(16'd1);
        s0 = n_send;
        wr_dat(8'h77);
        open_ack = 1'b0;
        wr_ctl(16'h8603);
        settle();
        open_ack = 1'b1;
        chk("R4 nack flag", stat[0], 1);
        chk("R4 stop cleared", ctl_rdata, 16'h8600);
        chk("R4 not busy", busy, 0);
        chk("R4 no byte sent", n_send - s0, 0);
        clr_stat(4'b0001);
        chk("R4 nack cleared", stat[0], 0);
    endtask

    task automatic t_rx_normal();
        int r0, c0;
        logic [7:0] b;
        wr_ctl(16'h0000);
        wr_sa(10'h2A);
        wr_cnt(16'd6);
        r0 = n_recv; c0 = n_close;
        wr_ctl(16'h8403);
        settle();
        chk("R3 open dir read", last_rd, 1);
        chk("R8 fill to depth", n_recv - r0, 4);
        chk("R8 rrdy", stat[2], 1);
        chk("R8 count left", cnt_rdata, 2);
        rd_dat(b); chk("R8 read0", b, 8'(8'hA0 + r0));
        settle();
        chk("R8 refill one", n_recv - r0, 5);
        rd_dat(b); chk("R8 read1", b, 8'(8'hA0 + r0 + 1));
        settle();
        chk("R8 all received", n_recv - r0, 6);
        chk("R6 rx close", n_close - c0, 1);
        chk("R6 rx reload", cnt_rdata, 6);
        chk("R9 ardy not yet", stat[1], 0);
        rd_dat(b); chk("R8 read2", b, 8'(8'hA0 + r0 + 2));
        rd_dat(b); chk("R8 read3", b, 8'(8'hA0 + r0 + 3));
        rd_dat(b); chk("R8 read4", b, 8'(8'hA0 + r0 + 4));
        rd_dat(b); chk("R8 read5", b, 8'(8'hA0 + r0 + 5));
        settle();
        chk("R9 ardy on drain", stat[1], 1);
        chk("R9 master cleared", ctl_rdata, 16'h8000);
        chk("R14 idle reads no recv", n_recv - r0, 6);
    endtask

    task automatic t_rep_tx();
        int s0, c0;
        logic [7:0] b;
        wr_ctl(16'h0000);
        wr_cnt(16'd1);
        s0 = n_send; c0 = n_close;
        wr_dat(8'h81); wr_dat(8'h82); wr_dat(8'h83); wr_dat(8'h84);
        wr_ctl(16'h8605);
        settle();
        chk("R11 repeat sends all", n_send - s0, 4);
        chk("R11 last byte", sent[s0+3], 8'h84);
        chk("R11 xrdy", stat[3], 1);
        chk("R11 count unchanged", cnt_rdata, 1);
        chk("R11 no close", n_close - c0, 0);
        wr_ctl(16'h8606);
        wr_dat(8'h99);
        settle();
        chk("R12 close issued", n_close - c0, 1);
        chk("R12 no byte moved", n_send - s0, 4);
        chk("R12 busy drop", busy, 0);
        chk("R12 stop cleared", ctl_rdata, 16'h8604);
        chk("R12 reload", cnt_rdata, 1);
        rd_dat(b);
        chk("R12 byte kept", b, 8'h99);
    endtask

    task automatic t_rep_rx();
        int r0;
        logic [7:0] b;
        wr_ctl(16'h0000);
        wr_cnt(16'd2);
        r0 = n_recv;
        wr_ctl(16'h8405);
        settle();
        chk("R11 repeat fill", n_recv - r0, 4);
        chk("R11 rrdy", stat[2], 1);
        chk("R11 rx count unchanged", cnt_rdata, 2);
        rd_dat(b);
        settle();
        chk("R11 refill after read", n_recv - r0, 5);
    endtask

    task automatic t_byte_nack();
        int s0, c0;
        logic [7:0] b;
        wr_ctl(16'h0000);
        wr_cnt(16'd4);
        s0 = n_send; c0 = n_close;
        wr_dat(8'h61); wr_dat(8'h62); wr_dat(8'h63);
        nack_at = s0 + 1;
        wr_ctl(16'h8603);
        settle();
        nack_at = -1;
        chk("R13 sending stops", n_send - s0, 2);
        chk("R13 nack flag", stat[0], 1);
        chk("R13 stop cleared", ctl_rdata, 16'h8600);
        chk("R13 no close", n_close - c0, 0);
        chk("R13 count", cnt_rdata, 2);
        rd_dat(b);
        chk("R13 remaining byte", b, 8'h63);
        wr_ctl(16'h0000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_mask_and_clear();
        t_tx_auto_stop();
        t_tx_no_stop();
        t_tx_underrun();
        t_open_nack();
        t_rx_normal();
        t_rep_tx();
        t_rep_rx();
        t_byte_nack();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule